// File: doc/BRIEF.md
# Two-Wire Configuration Register Slave

This block is the configuration port of a multi-output clock buffer. It watches a two-wire SMBus-compatible bus (clock and data lines) and samples both lines with a fast system clock. It recognises start, repeated-start and stop conditions and answers to one fixed 7-bit device address. Through the bus a host reads and writes a small bank of 8-bit control registers. Those registers hold per-output enable bits, the output amplitude selection, an identification byte, and the byte-count value used by block reads.

Four transactions are supported: byte write, byte read, block write and block read. Bit 7 of the command code picks the kind, and bits 6:0 give the starting register index. A block write carries a byte count after the command code. A block read returns the count register first, then the data bytes. The block drives the data line only by pulling it low, for acknowledges and for zeros of read data. The decoded enables and amplitude fields leave the block as plain level outputs for the clock output stages.

Top module: `smb_cfg_slave`

## Requirements
- R1: The block acknowledges (pulls SDA low in the ninth bit) only the address bytes 0xD6 (write) and 0xD7 (read), i.e. 7-bit address 0x6B with R/W in bit 0. Any other address byte gets no acknowledge, SDA stays released, and the block ignores the bus until the next start.
- R2: The command code is acknowledged. Its bit 7 = 1 selects a byte access and bit 7 = 0 selects a block access. Bits 6:0 are the starting register index, and the index is kept for a following repeated-start read.
- R3: Byte write: the first data byte after the command is written to the indexed register. Any further data bytes in the same transfer are acknowledged and discarded.
- R4: Byte read: after a repeated start and address 0xD7, the block returns the indexed register MSB first. If the host acknowledges and reads on, the block returns 0xFF.
- R5: Block write: the byte after the command is a count N. The next N data bytes go to ascending registers starting at the index. Bytes past N are acknowledged and discarded.
- R6: Block read: the first byte returned is the value of register 4 (count C). It is followed by C registers in ascending order from the index, then 0xFF until the host sends NACK.
- R7: After reset the registers read 0x00, 0x15, 0xE0, 0x08, 0x06, 0xD8 for indices 0 to 5.
- R8: out_en[0], out_en[1] and out_en[2] follow register 1 bits 4, 2 and 0. out_en[3], out_en[4] and out_en[5] follow register 2 bits 7, 6 and 5. amp_sel follows register 5 bit 7, and amp_code follows register 5 bits 6:4.
- R9: An index of 6 or above reads as 0x00 and ignores writes.
- R10: sda_oe changes only while the synchronised SCL is low. It is released while the bus is idle and after every stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| out_en | output | 6 | Per-output enable, one bit per clock output |
| amp_sel | output | 1 | 1 = use programmed amplitude, 0 = default amplitude |
| amp_code | output | 3 | Amplitude code, 0 = 300 mV rising 100 mV per step |

## Verification
Each bus line passes two synchroniser flops and one edge-detect flop, so the block acts on the third clock edge after a line changes. An acknowledge or read-data bit therefore appears on SDA three clocks after the SCL fall that opens its bit slot. A register write, and the output fields decoded from it, takes effect three clocks after the SCL fall that ends the data byte. The bench holds each SCL half period for eight clocks and samples SDA at the middle of SCL high, well after the drive has settled. It compares the decoded outputs and the released SDA against its model on every clock, but only from six clocks after a stop. The model is updated at that point, so no comparison falls inside a transfer.

// File: rtl/smb_cfg_pkg.sv
package smb_cfg_pkg;

  localparam int BYTE_W    = 8;
  localparam int IDX_W     = 7;
  localparam int IDX_OE_LO = 1;
  localparam int IDX_OE_HI = 2;
  localparam int IDX_CNT   = 4;
  localparam int IDX_AMP   = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_WDAT,
    ST_ACK,
    ST_TX,
    ST_RACK
  } smb_state_t;

  // power-up content of each register
  function automatic logic [BYTE_W-1:0] reg_default(input int idx);
    case (idx)
      1:       return 8'h15;
      2:       return 8'hE0;
      3:       return 8'h08;
      4:       return 8'h06;
      5:       return 8'hD8;
      default: return 8'h00;
    endcase
  endfunction

  // byte to shift out next on a read stream
  function automatic logic [BYTE_W-1:0] next_tx(input logic hdr_pending,
                                                input logic [BYTE_W-1:0] left,
                                                input logic [BYTE_W-1:0] cnt_val,
                                                input logic [BYTE_W-1:0] reg_val);
    if (hdr_pending)
      return cnt_val;
    else if (left != '0)
      return reg_val;
    else
      return 8'hFF;
  endfunction

  // output-enable bit position inside its register for output k
  function automatic int oe_bit_pos(input int k);
    if (k < 3)
      return 4 - 2 * k;
    else
      return 10 - k;
  endfunction

endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic [STAGES-1:0] scl_pipe;
  logic [STAGES-1:0] sda_pipe;
  logic              scl_q;
  logic              sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s    = scl_pipe[STAGES-1];
  assign sda_s    = sda_pipe[STAGES-1];
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/smb_cfg_regs.sv
module smb_cfg_regs
  import smb_cfg_pkg::*;
#(
  parameter int NREG = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx,
  output logic [BYTE_W-1:0] rdata,
  output logic [BYTE_W-1:0] cnt_val,
  output logic [BYTE_W-1:0] oe_lo,
  output logic [BYTE_W-1:0] oe_hi,
  output logic [BYTE_W-1:0] amp_reg
);

  localparam int SEL_W = $clog2(NREG);

  logic [BYTE_W-1:0] bank [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        q <= reg_default(g);
      else if (we && (widx == IDX_W'(g)))
        q <= wdata;
    end
    assign bank[g] = q;
  end

  always_comb begin
    if (ridx < IDX_W'(NREG))
      rdata = bank[ridx[SEL_W-1:0]];
    else
      rdata = '0;
  end

  assign cnt_val = bank[IDX_CNT];
  assign oe_lo   = bank[IDX_OE_LO];
  assign oe_hi   = bank[IDX_OE_HI];
  assign amp_reg = bank[IDX_AMP];

endmodule

// File: rtl/smb_cfg_decode.sv
module smb_cfg_decode
  import smb_cfg_pkg::*;
#(
  parameter int NOUT = 6
) (
  input  logic [BYTE_W-1:0] oe_lo,
  input  logic [BYTE_W-1:0] oe_hi,
  input  logic [BYTE_W-1:0] amp_reg,
  output logic [NOUT-1:0]   out_en,
  output logic              amp_sel,
  output logic [2:0]        amp_code
);

  for (genvar k = 0; k < NOUT; k++) begin : g_oe
    if (k < 3) begin : g_lo
      assign out_en[k] = oe_lo[oe_bit_pos(k)];
    end else begin : g_hi
      assign out_en[k] = oe_hi[oe_bit_pos(k)];
    end
  end

  assign amp_sel  = amp_reg[7];
  assign amp_code = amp_reg[6:4];

  logic unused_bits;
  assign unused_bits = ^{oe_lo[7], oe_lo[5], oe_lo[3], oe_lo[1], oe_hi[4:0], amp_reg[3:0]};

endmodule

// File: rtl/smb_cfg_fsm.sv
module smb_cfg_fsm
  import smb_cfg_pkg::*;
#(
  parameter int         NREG     = 6,
  parameter logic [6:0] DEV_ADDR = 7'h6B
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              sda_s,
  input  logic [BYTE_W-1:0] rdata,
  input  logic [BYTE_W-1:0] cnt_val,
  output logic [IDX_W-1:0]  ptr_o,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [BYTE_W-1:0] wr_data,
  output logic              sda_drive,
  output logic              in_idle,
  output logic              byte_rx_done
);

  smb_state_t        st;
  smb_state_t        st_after;
  logic [BYTE_W-1:0] sh;
  logic [3:0]        bitn;
  logic [IDX_W-1:0]  ptr;
  logic              mode_byte;
  logic [BYTE_W-1:0] remaining;
  logic              hdr;
  logic [BYTE_W-1:0] txsh;
  logic              mack;
  logic              rx_state;
  logic [BYTE_W-1:0] tx_next;

  assign rx_state     = (st == ST_ADDR) || (st == ST_CMD) || (st == ST_CNT) || (st == ST_WDAT);
  assign byte_rx_done = rx_state && scl_fall && (bitn == 4'd8);
  assign wr_en        = byte_rx_done && (st == ST_WDAT) && (remaining != '0)
                        && (ptr < IDX_W'(NREG));
  assign wr_idx       = ptr;
  assign wr_data      = sh;
  assign ptr_o        = ptr;
  assign sda_drive    = (st == ST_ACK) || ((st == ST_TX) && !txsh[7]);
  assign in_idle      = (st == ST_IDLE);
  assign tx_next      = next_tx(hdr, remaining, cnt_val, rdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      st_after  <= ST_IDLE;
      sh        <= '0;
      bitn      <= '0;
      ptr       <= '0;
      mode_byte <= 1'b1;
      remaining <= '0;
      hdr       <= 1'b0;
      txsh      <= 8'hFF;
      mack      <= 1'b1;
    end else if (start_ev) begin
      st   <= ST_ADDR;
      bitn <= '0;
    end else if (stop_ev) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_ADDR, ST_CMD, ST_CNT, ST_WDAT: begin
          if (scl_rise && (bitn < 4'd8)) begin
            sh   <= {sh[6:0], sda_s};
            bitn <= bitn + 4'd1;
          end else if (byte_rx_done) begin
            bitn <= '0;
            st   <= ST_ACK;
            case (st)
              ST_ADDR: begin
                if (sh[7:1] != DEV_ADDR) begin
                  st <= ST_IDLE;
                end else if (sh[0]) begin
                  st_after  <= ST_TX;
                  hdr       <= !mode_byte;
                  remaining <= mode_byte ? 8'd1 : cnt_val;
                end else begin
                  st_after <= ST_CMD;
                end
              end
              ST_CMD: begin
                mode_byte <= sh[7];
                ptr       <= sh[6:0];
                remaining <= 8'd1;
                st_after  <= sh[7] ? ST_WDAT : ST_CNT;
              end
              ST_CNT: begin
                remaining <= sh;
                st_after  <= ST_WDAT;
              end
              default: begin
                if (remaining != '0) begin
                  ptr       <= ptr + 1'b1;
                  remaining <= remaining - 8'd1;
                end
                st_after <= ST_WDAT;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bitn <= '0;
            st   <= st_after;
            if (st_after == ST_TX) begin
              txsh <= tx_next;
              if (hdr) begin
                hdr <= 1'b0;
              end else if (remaining != '0) begin
                ptr       <= ptr + 1'b1;
                remaining <= remaining - 8'd1;
              end
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (bitn == 4'd7) begin
              st <= ST_RACK;
            end else begin
              bitn <= bitn + 4'd1;
              txsh <= {txsh[6:0], 1'b1};
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= sda_s;
          end else if (scl_fall) begin
            if (!mack) begin
              st   <= ST_TX;
              bitn <= '0;
              txsh <= tx_next;
              if (hdr) begin
                hdr <= 1'b0;
              end else if (remaining != '0) begin
                ptr       <= ptr + 1'b1;
                remaining <= remaining - 8'd1;
              end
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/smb_cfg_slave.sv
module smb_cfg_slave
  import smb_cfg_pkg::*;
#(
  parameter int         NREG        = 6,
  parameter int         NOUT        = 6,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'h6B
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl_i,
  input  logic            sda_i,
  output logic            sda_oe,
  output logic [NOUT-1:0] out_en,
  output logic            amp_sel,
  output logic [2:0]      amp_code
);

  // named internal events, observed by the bound checker
  logic              scl_s;
  logic              sda_s;
  logic              ev_scl_rise;
  logic              ev_scl_fall;
  logic              ev_start;
  logic              ev_stop;
  logic              bus_idle;
  logic              rx_done;
  logic              reg_we;
  logic [IDX_W-1:0]  reg_widx;
  logic [BYTE_W-1:0] reg_wdata;
  logic [IDX_W-1:0]  reg_ridx;
  logic [BYTE_W-1:0] reg_rdata;
  logic [BYTE_W-1:0] cnt_val;
  logic [BYTE_W-1:0] oe_lo;
  logic [BYTE_W-1:0] oe_hi;
  logic [BYTE_W-1:0] amp_reg;

  smb_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (ev_scl_rise),
    .scl_fall (ev_scl_fall),
    .start_ev (ev_start),
    .stop_ev  (ev_stop)
  );

  smb_cfg_fsm #(.NREG(NREG), .DEV_ADDR(DEV_ADDR)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .scl_rise     (ev_scl_rise),
    .scl_fall     (ev_scl_fall),
    .start_ev     (ev_start),
    .stop_ev      (ev_stop),
    .sda_s        (sda_s),
    .rdata        (reg_rdata),
    .cnt_val      (cnt_val),
    .ptr_o        (reg_ridx),
    .wr_en        (reg_we),
    .wr_idx       (reg_widx),
    .wr_data      (reg_wdata),
    .sda_drive    (sda_oe),
    .in_idle      (bus_idle),
    .byte_rx_done (rx_done)
  );

  smb_cfg_regs #(.NREG(NREG)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (reg_we),
    .widx    (reg_widx),
    .wdata   (reg_wdata),
    .ridx    (reg_ridx),
    .rdata   (reg_rdata),
    .cnt_val (cnt_val),
    .oe_lo   (oe_lo),
    .oe_hi   (oe_hi),
    .amp_reg (amp_reg)
  );

  smb_cfg_decode #(.NOUT(NOUT)) u_dec (
    .oe_lo    (oe_lo),
    .oe_hi    (oe_hi),
    .amp_reg  (amp_reg),
    .out_en   (out_en),
    .amp_sel  (amp_sel),
    .amp_code (amp_code)
  );

endmodule

// File: rtl/smb_cfg_chk.sv
module smb_cfg_chk #(
  parameter int NREG = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       sda_oe,
  input logic       scl_s,
  input logic       ev_stop,
  input logic       ev_scl_fall,
  input logic       bus_idle,
  input logic       rx_done,
  input logic       reg_we,
  input logic [6:0] reg_widx
);

  AST_DRIVE_WHILE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s); // R10

  AST_RELEASE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> !sda_oe); // R10

  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    bus_idle |-> !sda_oe); // R1

  AST_WRITE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (reg_widx < 7'(NREG))); // R9

  AST_WRITE_AT_BYTE_END: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (rx_done && ev_scl_fall)); // R3

  AST_WRITE_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !bus_idle); // R5

endmodule

bind smb_cfg_slave smb_cfg_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sda_oe      (sda_oe),
  .scl_s       (scl_s),
  .ev_stop     (ev_stop),
  .ev_scl_fall (ev_scl_fall),
  .bus_idle    (bus_idle),
  .rx_done     (rx_done),
  .reg_we      (reg_we),
  .reg_widx    (reg_widx)
);

// File: tb/tb_smb_cfg_slave.sv
`timescale 1ns/1ps
module tb_smb_cfg_slave;

  localparam int H = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic [5:0] out_en;
  logic       amp_sel;
  logic [2:0] amp_code;
  logic       sda_bus;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  logic cmp_en = 1'b0;

  logic [7:0] mreg [6];
  logic [7:0] wq [$];
  logic [7:0] eq [$];

  assign sda_bus = sda_m & ~sda_oe;

  always #2 clk = ~clk;

  smb_cfg_slave dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe   (sda_oe),
    .out_en   (out_en),
    .amp_sel  (amp_sel),
    .amp_code (amp_code)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] model_rd(input int idx);
    return (idx < 6) ? mreg[idx] : 8'h00;
  endfunction

  function automatic logic [5:0] model_oe();
    logic [5:0] v;
    v[0] = mreg[1][4];
    v[1] = mreg[1][2];
    v[2] = mreg[1][0];
    v[3] = mreg[2][7];
    v[4] = mreg[2][6];
    v[5] = mreg[2][5];
    return v;
  endfunction

  // model comparison on every clock while the bus rests
  always @(negedge clk) begin
    cyc++;
    if (cmp_en) begin
      check("R8 out_en", 32'(out_en), 32'(model_oe()));
      check("R8 amp_sel", 32'(amp_sel), 32'(mreg[5][7]));
      check("R8 amp_code", 32'(amp_code), 32'(mreg[5][6:4]));
      check("R10 sda released", 32'(sda_oe), 32'd0);
    end
  end

  initial begin
    wait (cyc >= 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=<150000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic hclk();
    repeat (H) @(negedge clk);
  endtask

  task automatic bstart();
    sda_m = 1'b1; hclk();
    scl_m = 1'b1; hclk();
    sda_m = 1'b0; hclk();
    scl_m = 1'b0; hclk();
  endtask

  task automatic bstop();
    sda_m = 1'b0; hclk();
    scl_m = 1'b1; hclk();
    sda_m = 1'b1; hclk();
  endtask

  task automatic wbit(input logic b);
    sda_m = b; hclk();
    scl_m = 1'b1; hclk();
    scl_m = 1'b0;
  endtask

  task automatic rbit(output logic b);
    sda_m = 1'b1; hclk();
    scl_m = 1'b1;
    repeat (H / 2) @(negedge clk);
    b = sda_bus;
    repeat (H / 2) @(negedge clk);
    scl_m = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic a;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(a);
    ack = !a;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic host_ack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      d[i] = b;
    end
    wbit(host_ack ? 1'b0 : 1'b1);
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
    cmp_en = 1'b1;
  endtask

  // byte write with optional extra data bytes (R3)
  task automatic byte_write(input int idx, input logic [7:0] d, input int nextra);
    logic a;
    cmp_en = 1'b0;
    bstart();
    wbyte(8'hD6, a); check("R1 write address ack", 32'(a), 32'd1);
    wbyte(8'h80 | 8'(idx), a); check("R2 byte command ack", 32'(a), 32'd1);
    wbyte(d, a); check("R3 data ack", 32'(a), 32'd1);
    for (int i = 0; i < nextra; i++) begin
      wbyte(8'h11 + 8'(i), a); check("R3 extra byte ack", 32'(a), 32'd1);
    end
    bstop();
    if (idx < 6) mreg[idx] = d;
    settle();
  endtask

  // byte read, nfollow extra bytes acked by the host (R4)
  task automatic byte_read_chk(input int idx, input int nfollow);
    logic a;
    logic [7:0] d;
    cmp_en = 1'b0;
    bstart();
    wbyte(8'hD6, a); check("R1 write address ack", 32'(a), 32'd1);
    wbyte(8'h80 | 8'(idx), a); check("R2 byte command ack", 32'(a), 32'd1);
    bstart();
    wbyte(8'hD7, a); check("R1 read address ack", 32'(a), 32'd1);
    rbyte(d, nfollow > 0);
    check((idx < 6) ? "R4 byte read data" : "R9 out of range read", 32'(d), 32'(model_rd(idx)));
    for (int i = 0; i < nfollow; i++) begin
      rbyte(d, i < nfollow - 1);
      check("R4 read past single byte", 32'(d), 32'hFF);
    end
    bstop();
    settle();
  endtask

  // block write: count then bytes from wq (R5)
  task automatic block_write(input int idx, input logic [7:0] cnt);
    logic a;
    cmp_en = 1'b0;
    bstart();
    wbyte(8'hD6, a); check("R1 write address ack", 32'(a), 32'd1);
    wbyte(8'(idx) & 8'h7F, a); check("R2 block command ack", 32'(a), 32'd1);
    wbyte(cnt, a); check("R5 count ack", 32'(a), 32'd1);
    for (int i = 0; i < wq.size(); i++) begin
      wbyte(wq[i], a); check("R5 block data ack", 32'(a), 32'd1);
      if (i < int'(cnt) && (idx + i) < 6) mreg[idx + i] = wq[i];
    end
    bstop();
    settle();
  endtask

  // block read: expectation built from the model, plus nff trailing 0xFF (R6)
  task automatic block_read_chk(input int idx, input int nff);
    logic a;
    logic [7:0] d;
    eq.delete();
    eq.push_back(mreg[4]);
    for (int k = 0; k < int'(mreg[4]); k++) eq.push_back(model_rd(idx + k));
    for (int k = 0; k < nff; k++) eq.push_back(8'hFF);
    cmp_en = 1'b0;
    bstart();
    wbyte(8'hD6, a); check("R1 write address ack", 32'(a), 32'd1);
    wbyte(8'(idx) & 8'h7F, a); check("R2 block command ack", 32'(a), 32'd1);
    bstart();
    wbyte(8'hD7, a); check("R1 read address ack", 32'(a), 32'd1);
    for (int i = 0; i < eq.size(); i++) begin
      rbyte(d, i < eq.size() - 1);
      check("R6 block read byte", 32'(d), 32'(eq[i]));
    end
    bstop();
    settle();
  endtask

  initial begin
    logic a;
    mreg[0] = 8'h00; mreg[1] = 8'h15; mreg[2] = 8'hE0;
    mreg[3] = 8'h08; mreg[4] = 8'h06; mreg[5] = 8'hD8;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // reset state (R7, R8)
    check("R7 reset out_en", 32'(out_en), 32'h3F);
    check("R7 reset amp_sel", 32'(amp_sel), 32'd1);
    check("R7 reset amp_code", 32'(amp_code), 32'd5);
    check("R10 reset sda", 32'(sda_oe), 32'd0);
    cmp_en = 1'b1;

    // default register contents (R7)
    for (int i = 0; i < 6; i++) byte_read_chk(i, 0);

    // foreign address gets no acknowledge and is ignored (R1)
    cmp_en = 1'b0;
    bstart();
    wbyte(8'hA0, a); check("R1 foreign address nack", 32'(a), 32'd0);
    wbyte(8'h81, a); check("R1 ignored after mismatch", 32'(a), 32'd0);
    bstop();
    settle();
    check("R1 registers untouched", 32'(out_en), 32'h3F);

    // byte write to enable register (R3, R8)
    byte_write(1, 8'h04, 0);
    check("R8 out_en after write", 32'(out_en), 32'h3A);

    // extra bytes after a byte write are discarded (R3)
    byte_write(0, 8'hA5, 2);
    byte_read_chk(1, 0);
    byte_read_chk(0, 0);

    // amplitude fields (R8)
    byte_write(5, 8'h30, 0);
    check("R8 amp_sel programmed", 32'(amp_sel), 32'd0);
    check("R8 amp_code programmed", 32'(amp_code), 32'd3);

    // block write, third byte past the count is dropped (R5)
    wq.delete();
    wq.push_back(8'h10); wq.push_back(8'h20); wq.push_back(8'h33);
    block_write(1, 8'd2);
    check("R5 out_en after block write", 32'(out_en), 32'h21);
    byte_read_chk(3, 0);

    // block read of the whole bank with trailing fill (R6)
    block_read_chk(0, 2);

    // shorter count from the count register (R6)
    byte_write(4, 8'h02, 0);
    block_read_chk(2, 1);

    // out-of-range index (R9)
    byte_read_chk(9, 0);
    byte_write(9, 8'h5A, 0);
    byte_read_chk(9, 0);
    block_read_chk(5, 1);

    // single-byte read continued by the host (R4)
    byte_read_chk(3, 2);

    repeat (10) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule